// File: doc/BRIEF.md
# Group-Acknowledged Retransmission Sender

This block sits between a local packet source and a lossy link. Each fixed-length packet offered by the source is passed to the network in the same cycle, tagged with a sequence number, and a copy is kept in a window of `WIN` slots. The receiver answers a complete group of `WIN` packets with one acknowledgement word. That word names the tag of the oldest packet in the group and holds one status bit per packet. Packets reported as failed are offered again, and the group is released only when every one of its packets has been confirmed. A cycle counter covers the case where no answer arrives: when it expires, every packet sent but not yet confirmed is offered again.

The control is a four-state machine. `ST_IDLE`: the window is empty and the timer is held at zero. `ST_FILL`: part of the window is used, new packets are still accepted, and the timer runs. `ST_WAIT`: all `WIN` packets have been sent, the block waits for an acknowledgement, and the timer runs. `ST_RESEND`: stored packets are offered again in ascending tag order, no input is accepted, and the timer is held at zero. The transitions are these. IDLE to FILL on the first accepted packet (to WAIT directly when `WIN` is 1). FILL to WAIT on the packet that fills the window. FILL to RESEND on timer expiry. WAIT to IDLE on a matching acknowledgement that completes the group. WAIT to RESEND on a matching acknowledgement with failures, or on timer expiry. RESEND to WAIT or FILL once the last marked packet has gone, depending on whether the window is full.

With `WIN` set to 1 the block becomes a stop-and-wait sender: one packet is held, and each packet costs a send plus an acknowledgement round trip.

Top module: `retx_window_sender`

## Requirements
- R1: After reset `out_valid` is low, `in_ready` equals `out_ready`, and the first accepted packet carries sequence tag 0.
- R2: In ST_IDLE and ST_FILL an input packet is presented on the output in the same cycle, with `out_data` equal to `in_data` and `out_seq` equal to the group base tag plus the number of packets already in the window. It is transferred and stored when `in_valid` and `out_ready` are both high.
- R3: `in_ready` is low whenever the window holds `WIN` packets.
- R4: An acknowledgement has bit i of `ack_ok` set to 1 when packet base+i arrived correctly, and 0 when it failed. It takes effect only in ST_WAIT with `ack_base` equal to the oldest held tag. Any other acknowledgement changes nothing.
- R5: When every packet of the group has been confirmed, the window is released, the base tag advances by `WIN` modulo 2^`SEQ_W`, and input is accepted again.
- R6: Failed packets are offered again with their original data and tag, in ascending tag order, before any new packet.
- R7: A packet confirmed by any earlier acknowledgement of the group is never sent again. Confirmations from successive acknowledgements accumulate.
- R8: If the timer reaches `TIMEOUT` cycles with no accepted acknowledgement, the first resend is offered `TIMEOUT` clock edges after the edge that started the timer. All sent, unconfirmed packets then follow in ascending order.
- R9: The timer starts from zero when a group's first packet is accepted, when an acknowledgement is accepted, and when a resend finishes. An ignored acknowledgement does not restart it. With the window empty, nothing is ever retransmitted.
- R10: A timeout with a partly filled window resends only the packets already sent, then accepts new packets into the remaining slots.
- R11: While a resend is offered and `out_ready` is low, `out_valid`, `out_seq` and `out_data` hold steady.
- R12: With `WIN` = 1, one packet is held. Input is blocked until its acknowledgement arrives, and tags advance by one per packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source packet valid |
| in_ready | output | 1 | Block accepts the source packet |
| in_data | input | DATA_W | Source packet payload |
| out_valid | output | 1 | Network packet valid |
| out_ready | input | 1 | Network accepts the packet |
| out_data | output | DATA_W | Network packet payload |
| out_seq | output | SEQ_W | Sequence tag of the network packet |
| ack_valid | input | 1 | Acknowledgement strobe |
| ack_base | input | SEQ_W | Tag of the first packet the acknowledgement covers |
| ack_ok | input | WIN | Per-packet status, bit i for packet base+i, 1 = arrived correctly |

## Verification
The embedded properties check, on every cycle, the following: input is blocked while the window is full; a resend held under backpressure does not change; resend tags rise within one resend pass; a confirmed packet is never marked for resend; a stray acknowledgement leaves the base tag and state unchanged; and the timer cannot expire with an empty window. The bench scenarios cover what spans many cycles. These are the exact data and order of every packet on the network, the accumulation of confirmations across two acknowledgements, the exact cycle at which a timeout resend appears, the priority of resends over a waiting source packet, wraparound of the tag space, and stop-and-wait behaviour with a one-slot window.

// File: rtl/retx_pkg.sv
package retx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_WAIT   = 2'd2,
        ST_RESEND = 2'd3
    } retx_state_e;
endpackage

// File: rtl/retx_slot_store.sv
module retx_slot_store #(
    parameter int DATA_W = 16,
    parameter int WIN    = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_q [WIN];

    for (genvar g = 0; g < WIN; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(g)) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < WIN; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = slot_q[i];
            end
        end
    end
endmodule

// File: rtl/retx_pick.sv
module retx_pick #(
    parameter int WIN   = 4,
    parameter int IDX_W = 2
) (
    input  logic [WIN-1:0]   mask,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // lowest marked slot wins, giving ascending resend order
    always_comb begin
        idx = '0;
        for (int i = WIN - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = IDX_W'(i);
            end
        end
        any = |mask;
    end
endmodule

// File: rtl/retx_timer.sv
module retx_timer #(
    parameter int TIMEOUT = 40,
    parameter int TMR_W   = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expired
);
    logic [TMR_W-1:0] cnt_q;

    assign expired = run && (cnt_q == TMR_W'(TIMEOUT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || !run || expired) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + TMR_W'(1);
        end
    end
endmodule

// File: rtl/retx_window_sender.sv
module retx_window_sender
    import retx_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int WIN     = 4,
    parameter int SEQ_W   = 4,
    parameter int TIMEOUT = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [SEQ_W-1:0]  out_seq,
    input  logic              ack_valid,
    input  logic [SEQ_W-1:0]  ack_base,
    input  logic [WIN-1:0]    ack_ok
);
    localparam int IDX_W = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int CNT_W = $clog2(WIN + 1);
    localparam int TMR_W = $clog2(TIMEOUT);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIN);

    retx_state_e       state_q, state_d;
    logic [SEQ_W-1:0]  base_q, base_d;
    logic [CNT_W-1:0]  fill_q, fill_d;
    logic [WIN-1:0]    done_q, done_d;
    logic [WIN-1:0]    pend_q, pend_d;

    logic              tmo, tmr_run;
    logic              new_fire, res_fire, ack_take;
    logic [WIN-1:0]    ack_merged, sent_mask, pick_bit;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_any;
    logic [DATA_W-1:0] rd_data;

    assign tmr_run    = (state_q == ST_FILL) || (state_q == ST_WAIT);
    assign ack_take   = (state_q == ST_WAIT) && ack_valid && (ack_base == base_q);
    assign ack_merged = done_q | ack_ok;
    assign new_fire   = in_valid && in_ready;
    assign res_fire   = (state_q == ST_RESEND) && out_ready && pick_any;
    assign pick_bit   = WIN'(1) << pick_idx;

    always_comb begin
        for (int i = 0; i < WIN; i++) begin
            sent_mask[i] = (CNT_W'(i) < fill_q);
        end
    end

    retx_timer #(.TIMEOUT(TIMEOUT), .TMR_W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .clear(ack_take), .expired(tmo)
    );

    retx_pick #(.WIN(WIN), .IDX_W(IDX_W)) u_pick (
        .mask(pend_q), .idx(pick_idx), .any(pick_any)
    );

    retx_slot_store #(.DATA_W(DATA_W), .WIN(WIN), .IDX_W(IDX_W)) u_store (
        .clk(clk), .wr_en(new_fire), .wr_idx(IDX_W'(fill_q)), .wr_data(in_data),
        .rd_idx(pick_idx), .rd_data(rd_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            fill_q  <= '0;
            done_q  <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            fill_q  <= fill_d;
            done_q  <= done_d;
            pend_q  <= pend_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        fill_d  = fill_q;
        done_d  = done_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (new_fire) begin
                    fill_d  = CNT_W'(1);
                    state_d = (WIN == 1) ? ST_WAIT : ST_FILL;
                end
            end
            ST_FILL: begin
                if (tmo) begin
                    pend_d  = sent_mask;
                    state_d = ST_RESEND;
                end else if (new_fire) begin
                    fill_d = fill_q + CNT_W'(1);
                    if (fill_q + CNT_W'(1) == CNT_FULL) begin
                        state_d = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (ack_take) begin
                    if (&ack_merged) begin
                        base_d  = base_q + SEQ_W'(WIN);
                        fill_d  = '0;
                        done_d  = '0;
                        state_d = ST_IDLE;
                    end else begin
                        done_d  = ack_merged;
                        pend_d  = ~ack_merged;
                        state_d = ST_RESEND;
                    end
                end else if (tmo) begin
                    pend_d  = ~done_q;
                    state_d = ST_RESEND;
                end
            end
            ST_RESEND: begin
                if (res_fire) begin
                    pend_d = pend_q & ~pick_bit;
                    if ((pend_q & ~pick_bit) == '0) begin
                        state_d = (fill_q == CNT_FULL) ? ST_WAIT : ST_FILL;
                    end
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_seq   = base_q;
        unique case (state_q)
            ST_IDLE, ST_FILL: begin
                in_ready  = out_ready && !tmo;
                out_valid = in_valid && !tmo;
                out_data  = in_data;
                out_seq   = base_q + SEQ_W'(fill_q);
            end
            ST_WAIT: begin
                in_ready = 1'b0;
            end
            ST_RESEND: begin
                out_valid = pick_any;
                out_data  = rd_data;
                out_seq   = base_q + SEQ_W'(pick_idx);
            end
        endcase
    end

    logic [SEQ_W-1:0] seq_off;
    assign seq_off = out_seq - base_q;

    // R3
    full_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == CNT_FULL) |-> !in_ready);

    // R6
    resend_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_fire |=> (state_q != ST_RESEND) || (seq_off > $past(seq_off)));

    // R11
    resend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESEND && !out_ready)
        |=> (out_valid && $stable(out_seq) && $stable(out_data)));

    // R4
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && ack_valid && ack_base != base_q && !tmo)
        |=> (state_q == ST_WAIT && $stable(base_q)));

    // R5
    base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && (&ack_merged)) |=> (base_q == $past(base_q) + SEQ_W'(WIN)));

    // R7
    no_resend_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESEND) |-> ((pend_q & done_q) == '0));

    // R9
    idle_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == '0) |-> !tmo);
endmodule

// File: tb/retx_window_sender_tb.sv
`timescale 1ns/1ps
module retx_window_sender_tb;
    localparam int DW = 16;
    localparam int W  = 4;
    localparam int SW = 4;
    localparam int TO = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
    logic [DW-1:0] in_data = '0, out_data;
    logic [SW-1:0] out_seq, ack_base = '0;
    logic          ack_valid = 1'b0;
    logic [W-1:0]  ack_ok = '0;

    logic          s_in_valid = 1'b0, s_in_ready, s_out_valid, s_out_ready = 1'b1;
    logic [DW-1:0] s_in_data = '0, s_out_data;
    logic [SW-1:0] s_out_seq, s_ack_base = '0;
    logic          s_ack_valid = 1'b0;
    logic [0:0]    s_ack_ok = '0;

    retx_window_sender #(.DATA_W(DW), .WIN(W), .SEQ_W(SW), .TIMEOUT(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_seq(out_seq),
        .ack_valid(ack_valid), .ack_base(ack_base), .ack_ok(ack_ok));

    retx_window_sender #(.DATA_W(DW), .WIN(1), .SEQ_W(SW), .TIMEOUT(TO)) u_saw (
        .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .in_ready(s_in_ready), .in_data(s_in_data),
        .out_valid(s_out_valid), .out_ready(s_out_ready), .out_data(s_out_data), .out_seq(s_out_seq),
        .ack_valid(s_ack_valid), .ack_base(s_ack_base), .ack_ok(s_ack_ok));

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int acc_cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [SW-1:0] q_seq [$];
    logic [DW-1:0] q_data [$];
    string         q_req [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_pkt(input logic [SW-1:0] s, input logic [DW-1:0] d, input string req);
        q_seq.push_back(s);
        q_data.push_back(d);
        q_req.push_back(req);
    endtask

    // driver: called at a falling edge, returns at the falling edge after acceptance
    task automatic send(input logic [SW-1:0] s, input logic [DW-1:0] d, input string req);
        bit ok;
        expect_pkt(s, d, req);
        in_valid = 1'b1;
        in_data  = d;
        do begin
            #1;
            ok = in_ready;
            acc_cyc = cyc;
            @(negedge clk);
        end while (!ok);
        in_valid = 1'b0;
    endtask

    task automatic ack(input logic [SW-1:0] b, input logic [W-1:0] m);
        ack_valid = 1'b1;
        ack_base  = b;
        ack_ok    = m;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: scoreboard compare and hold check
    logic          hold_v = 1'b0;
    logic [SW-1:0] hold_seq;
    logic [DW-1:0] hold_data;
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (hold_v) begin
                    // R11 held resend must not change
                    chk(out_valid && out_seq == hold_seq && out_data == hold_data,
                        "R11", int'(out_data), int'(hold_data));
                end
                hold_v = out_valid && !out_ready;
                hold_seq = out_seq;
                hold_data = out_data;
                if (out_valid && out_ready) begin
                    if (q_seq.size() == 0) begin
                        // R9 no unexpected transmissions
                        chk(1'b0, "R9", int'(out_seq), -1);
                    end else begin
                        chk(out_seq == q_seq[0] && out_data == q_data[0], q_req[0],
                            int'({out_seq, out_data}), int'({q_seq[0], q_data[0]}));
                        void'(q_seq.pop_front());
                        void'(q_data.pop_front());
                        void'(q_req.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    int acc0;
    initial begin
        idle(3);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(!out_valid, "R1", int'(out_valid), 0);
        chk(in_ready == out_ready, "R1", int'(in_ready), int'(out_ready));
        @(negedge clk);

        // group 0: all ok
        send(4'd0, 16'hA000, "R1");
        send(4'd1, 16'hA001, "R2");
        send(4'd2, 16'hA002, "R2");
        send(4'd3, 16'hA003, "R2");
        #1;
        chk(!in_ready, "R3", int'(in_ready), 0);
        @(negedge clk);
        idle(2);
        ack(4'd0, 4'b1111);
        #1;
        chk(in_ready, "R5", int'(in_ready), 1);
        @(negedge clk);

        // group 4: stray ack, two failures, then accumulated confirmation
        send(4'd4, 16'hB004, "R2");
        send(4'd5, 16'hB005, "R2");
        send(4'd6, 16'hB006, "R2");
        send(4'd7, 16'hB007, "R2");
        idle(2);
        ack(4'd0, 4'b1111);
        #1;
        chk(!in_ready && !out_valid, "R4", int'({in_ready, out_valid}), 0);
        @(negedge clk);
        out_ready = 1'b0;
        expect_pkt(4'd4, 16'hB004, "R6");
        expect_pkt(4'd6, 16'hB006, "R6");
        ack(4'd4, 4'b1010);
        idle(3);
        out_ready = 1'b1;
        idle(4);
        ack(4'd4, 4'b0101);
        #1;
        chk(in_ready, "R7", int'(in_ready), 1);
        @(negedge clk);

        // group 8: timeout resends whole window; stray ack does not restart timer
        send(4'd8, 16'hC008, "R2");
        acc0 = acc_cyc;
        send(4'd9, 16'hC009, "R2");
        send(4'd10, 16'hC00A, "R2");
        send(4'd11, 16'hC00B, "R2");
        expect_pkt(4'd8, 16'hC008, "R8");
        expect_pkt(4'd9, 16'hC009, "R8");
        expect_pkt(4'd10, 16'hC00A, "R8");
        expect_pkt(4'd11, 16'hC00B, "R8");
        while (cyc < acc0 + 20) @(negedge clk);
        ack(4'd0, 4'b1111);
        forever begin
            @(negedge clk);
            #1;
            if (out_valid) break;
        end
        chk(cyc == acc0 + TO + 1, "R8", cyc - acc0, TO + 1);
        @(negedge clk);
        idle(6);
        ack(4'd8, 4'b1111);
        idle(2);

        // group 12: one failure, timer restarts on accepted ack
        send(4'd12, 16'hD00C, "R2");
        send(4'd13, 16'hD00D, "R2");
        send(4'd14, 16'hD00E, "R2");
        send(4'd15, 16'hD00F, "R2");
        idle(30);
        expect_pkt(4'd12, 16'hD00C, "R6");
        ack(4'd12, 4'b1110);
        idle(30);
        #1;
        chk(!out_valid, "R9", int'(out_valid), 0);
        @(negedge clk);
        ack(4'd12, 4'b0001);
        #1;
        chk(in_ready, "R5", int'(in_ready), 1);
        @(negedge clk);

        // wrapped group 0: partial-window timeout, resend before waiting packet
        send(4'd0, 16'hE000, "R5");
        acc0 = acc_cyc;
        send(4'd1, 16'hE001, "R5");
        expect_pkt(4'd0, 16'hE000, "R10");
        expect_pkt(4'd1, 16'hE001, "R10");
        while (cyc < acc0 + TO) @(negedge clk);
        send(4'd2, 16'hE002, "R6");
        chk(acc_cyc == acc0 + TO + 3, "R6", acc_cyc - acc0, TO + 3);
        send(4'd3, 16'hE003, "R10");
        idle(3);
        ack(4'd0, 4'b1111);
        idle(100);
        #1;
        chk(!out_valid, "R9", int'(out_valid), 0);
        chk(q_seq.size() == 0, "R6", q_seq.size(), 0);
        @(negedge clk);

        // one-slot window: stop-and-wait
        s_in_valid = 1'b1;
        s_in_data  = 16'hBEEF;
        #1;
        chk(s_in_ready && s_out_valid && s_out_seq == 4'd0, "R12", int'(s_out_seq), 0);
        @(negedge clk);
        s_in_valid = 1'b0;
        #1;
        chk(!s_in_ready, "R12", int'(s_in_ready), 0);
        @(negedge clk);
        s_ack_valid = 1'b1; s_ack_base = 4'd0; s_ack_ok = 1'b1;
        @(negedge clk);
        s_ack_valid = 1'b0;
        s_in_valid = 1'b1;
        s_in_data  = 16'h1234;
        #1;
        chk(s_in_ready && s_out_seq == 4'd1, "R12", int'(s_out_seq), 1);
        @(negedge clk);
        s_in_valid = 1'b0;
        s_ack_valid = 1'b1; s_ack_base = 4'd1; s_ack_ok = 1'b0;
        @(negedge clk);
        s_ack_valid = 1'b0;
        #1;
        chk(s_out_valid && s_out_seq == 4'd1 && s_out_data == 16'h1234, "R12",
            int'(s_out_data), 16'h1234);
        @(negedge clk);
        s_ack_valid = 1'b1; s_ack_base = 4'd1; s_ack_ok = 1'b1;
        @(negedge clk);
        s_ack_valid = 1'b0;
        #1;
        chk(s_in_ready && s_out_seq == 4'd2, "R12", int'(s_out_seq), 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule